// File: doc/BRIEF.md
# Fixed-Frequency Constant-Current Chopper

This block is the digital controller for the four low-side switches of a unipolar stepper driver. The switches are the two halves of winding A and the two halves of winding B. A free-running divider turns the fast clock into one PWM period that both windings share. On the set edge that starts each period, every winding turns on the half that the phase sequencer requests. It then holds that switch on until its comparator trip input reports that the sensed current has reached the reference. After a trip the switch stays off for the rest of the period.

A blanking window follows each turn-on, and trips are ignored inside it so that switching spikes cannot end the on-time early. When a winding moves from one half to the other, the new half is held off for a dead interval counted from the set edge. The enable input removes all drive at once.

The sequencer drives `req`, the bench or a comparator front end drives `trip`, and `gate` goes to the switch drivers. The set edges fall on every clock edge whose count since reset release is a whole multiple of `PERIOD`. With the defaults and a 200 MHz clock, the period is about 45 kHz, the blanking window is 1 µs and the dead interval is 3.75 µs. The parameters must satisfy `BLANK >= 1`, `DEAD >= 1` and `DEAD + BLANK < PERIOD`.

Top module: `chopper_ctl`

## Requirements
- R1: Set edges occur at clock edges number PERIOD, 2·PERIOD, and so on, counted from reset release. No switch is on before the first set edge.
- R2: A trip held high turns the active switch off after exactly BLANK cycles of on-time.
- R3: With no trip, the requested switch stays on for the whole period and continues without a gap into the next period when the same half is requested.
- R4: A trip that lasts only inside the blanking window has no effect on the switch.
- R5: A trip seen after blanking turns the switch off at the next clock edge. The switch then stays off until the next set edge, even after the trip goes away.
- R6: A winding whose request bits are both 0, or both 1, is off for the whole period. This is the zero-ratio case.
- R7: A low `en` forces all `gate` bits to 0 in the same cycle. After `en` returns high, the switches stay off until the next set edge.
- R8: When the requested half of a winding changes, both halves of that winding are off for DEAD cycles after the set edge. The new half then turns on with a fresh blanking window, and trips during the dead interval are ignored.
- R9: Both windings take their turn-on from the same set edge. Each winding is cut only by its own trip bit (`trip[0]` for A, `trip[1]` for B).
- R10: `req` is sampled only at set edges. A change in the middle of a period takes effect at the next set edge.
- R11: Reset clears all switches to off. The two halves of one winding are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all counters run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Drive enable; low cuts all switches at once |
| req | input | 4 | Requested switches: bit0 A, bit1 A-bar, bit2 B, bit3 B-bar |
| trip | input | 2 | Current-reached flags: bit0 winding A, bit1 winding B |
| gate | output | 4 | Switch drive, same bit order as `req` |

## Verification
The chopper is driven with several trip patterns. A trip held low shows the switch held on for the full period. A trip held from the set edge measures the blanking length exactly. A short pulse inside the window shows that blanking masks it, and a single-cycle pulse after the window shows the off-latch holding to the period end. The request patterns cover one winding, both windings together, zero-ratio codes, a change in the middle of a period and a change of half. Together they separate the shared set edge, the sampling of `req` at set edges only, and the dead interval. An enable drop in the middle of a period separates the immediate cut from the wait for the next set edge.

// File: rtl/chopper_ctl.sv
module chopper_ctl #(
  parameter int PERIOD = 4444,
  parameter int BLANK  = 200,
  parameter int DEAD   = 750
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] req,
  input  logic [1:0] trip,
  output logic [3:0] gate
);
  localparam int CW = $clog2(PERIOD);
  localparam int BW = $clog2(BLANK + 1);
  localparam int DW = $clog2(DEAD + 1);

  logic [CW-1:0] cnt;
  logic          set_tick;
  assign set_tick = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (set_tick) cnt <= '0;
    else               cnt <= cnt + 1'b1;

  logic          on_q  [2];
  logic          side_q[2];
  logic [BW-1:0] bcnt  [2];
  logic [DW-1:0] dcnt  [2];

  for (genvar p = 0; p < 2; p++) begin : g_wind
    logic act, want;
    assign act  = req[2*p] ^ req[2*p+1];
    assign want = req[2*p+1];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        on_q[p] <= 1'b0; side_q[p] <= 1'b0; bcnt[p] <= '0; dcnt[p] <= '0;
      end else if (!en) begin
        on_q[p] <= 1'b0; bcnt[p] <= '0; dcnt[p] <= '0;
      end else if (set_tick) begin
        if (!act) begin
          on_q[p] <= 1'b0; dcnt[p] <= '0;
        end else if (want != side_q[p]) begin
          on_q[p] <= 1'b0; side_q[p] <= want; dcnt[p] <= DW'(DEAD);
        end else begin
          on_q[p] <= 1'b1; bcnt[p] <= BW'(BLANK - 1); dcnt[p] <= '0;
        end
      end else if (dcnt[p] != '0) begin
        dcnt[p] <= dcnt[p] - 1'b1;
        if (dcnt[p] == DW'(1)) begin
          on_q[p] <= 1'b1; bcnt[p] <= BW'(BLANK - 1);
        end
      end else if (bcnt[p] != '0) begin
        bcnt[p] <= bcnt[p] - 1'b1;
      end else if (trip[p]) begin
        on_q[p] <= 1'b0;
      end

    assign gate[2*p]   = on_q[p] & en & ~side_q[p];
    assign gate[2*p+1] = on_q[p] & en &  side_q[p];

    // R2
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && on_q[p] && bcnt[p] != '0 && !set_tick |=> on_q[p]);
    // R5
    off_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !on_q[p] && dcnt[p] == '0 && !set_tick |=> !on_q[p]);
    // R8
    dead_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[2*p]) |-> !$past(gate[2*p+1]));
    // R8
    dead_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[2*p+1]) |-> !$past(gate[2*p]));
    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[2*p] && gate[2*p+1]));
  end

  // R7
  en_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> gate == 4'b0000);
endmodule

// File: tb/chopper_ctl_bench.sv
module chopper_ctl_bench;
  timeunit 1ns; timeprecision 100ps;
  localparam int P = 40, BL = 4, DT = 6;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  logic [3:0] req = 4'b0001;
  logic [1:0] trip = 2'b00;
  logic [3:0] gate;
  int checks = 0, failures = 0, ecnt = 0, s = 0;

  chopper_ctl #(.PERIOD(P), .BLANK(BL), .DEAD(DT)) u_chopper_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .req(req), .trip(trip), .gate(gate));

  always #2.5 clk = ~clk;
  always @(posedge clk) ecnt <= rst_n ? ecnt + 1 : 0;

  task automatic chk(string tag, logic [3:0] exp);
    checks++;
    if (gate !== exp) begin
      failures++;
      $display("FAIL %s gate=%b expected=%b at edge %0d", tag, gate, exp, ecnt);
    end
  endtask

  task automatic at(int n);
    while (ecnt != n) @(negedge clk);
  endtask

  function automatic int nxt();
    return (ecnt / P + 1) * P;
  endfunction

  task automatic t_reset_and_period;
    repeat (3) @(negedge clk);
    chk("R11 reset", 4'b0000);
    rst_n = 1'b1;
    at(P - 1); chk("R1 before first set", 4'b0000);
    at(P);     chk("R1 first set", 4'b0001);
    at(2*P-1); chk("R3 full period", 4'b0001);
    at(2*P);   chk("R3 no gap", 4'b0001);
  endtask

  task automatic t_blank_held;
    s = nxt(); trip = 2'b01;
    at(s + BL - 1); chk("R2 in window", 4'b0001);
    at(s + BL);     chk("R2 cut after BLANK", 4'b0000);
    trip = 2'b00;
  endtask

  task automatic t_blank_pulse;
    s = nxt(); trip = 2'b01;
    at(s + BL - 1); trip = 2'b00;
    at(s + BL + 1); chk("R4 masked trip", 4'b0001);
  endtask

  task automatic t_late_trip;
    s = nxt();
    at(s + 10); trip = 2'b01;
    at(s + 11); trip = 2'b00; chk("R5 cut", 4'b0000);
    at(s + 20); chk("R5 latched off", 4'b0000);
    at(s + P);  chk("R5 next set", 4'b0001);
  endtask

  task automatic t_mid_req_and_zero;
    s = nxt();
    at(s + 5); req = 4'b0000;
    at(s + P - 1); chk("R10 mid change ignored", 4'b0001);
    at(s + P); chk("R6 zero request", 4'b0000);
    req = 4'b0011;
    at(s + 2*P); chk("R6 both bits", 4'b0000);
    at(s + 2*P + P/2); chk("R6 both bits mid", 4'b0000);
  endtask

  task automatic t_shared_set;
    req = 4'b0101; s = nxt();
    at(s - 1); chk("R9 before set", 4'b0000);
    at(s); chk("R9 same edge", 4'b0101); trip = 2'b10;
    at(s + BL + 1); chk("R9 own trip", 4'b0001);
    trip = 2'b00;
  endtask

  task automatic t_side_change;
    req = 4'b0110; s = nxt(); trip = 2'b01;
    at(s);            chk("R8 dead start", 4'b0100);
    at(s + DT - 1);   chk("R8 dead end", 4'b0100);
    at(s + DT);       chk("R8 new half on", 4'b0110);
    at(s + DT + BL - 1); chk("R8 fresh blank", 4'b0110);
    at(s + DT + BL);  chk("R8 cut after blank", 4'b0100);
    trip = 2'b00;
  endtask

  task automatic t_enable;
    req = 4'b0010; s = nxt();
    at(s + 3); en = 1'b0; #1 chk("R7 immediate cut", 4'b0000);
    at(s + 5); en = 1'b1;
    at(s + 10); chk("R7 held off", 4'b0000);
    at(s + P);  chk("R7 resume at set", 4'b0010);
  endtask

  initial begin
    t_reset_and_period;
    t_blank_held;
    t_blank_pulse;
    t_late_trip;
    t_mid_req_and_zero;
    t_shared_set;
    t_side_change;
    t_enable;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++; failures++;
    $display("FAIL watchdog expired at edge %0d", ecnt);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule